// File: doc/BRIEF.md
# Fuse Controller Interrupt and Write-Protect Register Bank

This block is the register front end of a fuse controller. It answers a plain 32-bit register bus with word accesses, one write strobe and a combinational read path. It holds a write-protect latch, a sticky event status register, an interrupt mask and five 8-bit timing registers that software can read and write.

Hardware event pulses on `evt_i` set status bits. Software clears a status bit by writing a 1 to it. The mask cannot be written directly. Software changes it through an unmask register, which clears the mask bits given as 1s, and a mask-set register, which sets them.

A single level interrupt is raised whenever a status bit is set and its mask bit is clear. Until software writes the unlock key to the protect register, every write to any other address is dropped.

Top module: `fuse_irq_regbank`

Address map (byte addresses; any address not listed, including a misaligned one, is unmapped):

| Address | Register |
|---|---|
| 0x00 | protect |
| 0x04 | status |
| 0x08 | mask |
| 0x0C | unmask |
| 0x10 | mask-set |
| 0x14 | read time |
| 0x18 | setup/hold |
| 0x1C | setup/hold chip-select |
| 0x20 | margin read time |
| 0x24 | chip-select setup/hold variant |

## Requirements
- R1: The protect register (address 0x00, read as bit 0) is 1 after reset. A write of exactly 0x0000DF0D makes it 0. A write of any other value makes it 1. It accepts writes whether it is 0 or 1.
- R2: While protect is 1, a write to any address other than 0x00 changes no register and no output.
- R3: Status (0x04) uses live bits 0..14 and 31. `evt_i[14:0]` sets status bits 14..0, and `evt_i[15]` sets status bit 31. Writing a 1 to a live bit clears it. Bits 15..30 always read 0.
- R4: The mask (0x08) is 0x80007FFF after reset. A bus write to 0x08 leaves it unchanged.
- R5: Writing the unmask register (0x0C) clears the mask bits that are 1 in the data. Writing the mask-set register (0x10) sets them. Both registers read 0.
- R6: `irq_o` is 1 exactly when some status bit is 1 and its mask bit is 0. It follows the registers with no further delay.
- R7: A status bit stays set until a software write clears it or reset occurs.
- R8: The timing registers reset to these values: 0x19 at 0x14, 0xFF at 0x18, 0x11 at 0x1C, 0x3A at 0x20 and 0x16 at 0x24. A write stores data bits 7..0, and bits 31..8 read 0.
- R9: When an event and a clearing write hit the same status bit in the same cycle, the bit ends set.
- R10: A read from an unmapped address returns 0. A write to an unmapped address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for the current address |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| evt_i | input | 16 | Event pulses; bit 15 maps to status bit 31 |
| irq_o | output | 1 | Level interrupt |

## Verification
A hardware event and a software clearing write can both target the same status bit in one cycle. The bench provokes this by asserting the event bit during the write cycle of the status register, with that bit already set. It then reads status back and expects the bit still set (R9). A later write with no event must clear the bit. A second overlap is a clearing write to one bit while an event sets another bit. The bench expects both effects to land in that cycle.

// File: rtl/fuse_regbank_pkg.sv
package fuse_regbank_pkg;
  localparam int AW     = 8;
  localparam int DW     = 32;
  localparam int N_EVT  = 16;
  localparam int N_TIM  = 5;
  localparam int TIM_W  = 8;

  localparam logic [DW-1:0] UNLOCK_KEY = 32'h0000_DF0D;
  localparam logic [DW-1:0] STAT_LIVE  = 32'h8000_7FFF;
  localparam logic [DW-1:0] MASK_INIT  = STAT_LIVE;

  localparam logic [AW-1:0] A_PROT    = 8'h00;
  localparam logic [AW-1:0] A_STAT    = 8'h04;
  localparam logic [AW-1:0] A_MASK    = 8'h08;
  localparam logic [AW-1:0] A_UNMASK  = 8'h0C;
  localparam logic [AW-1:0] A_MASKSET = 8'h10;
  localparam logic [AW-1:0] A_TIM0    = 8'h14;

  // event vector to status positions: low 15 events land on bits 14..0, top event on bit 31
  function automatic logic [DW-1:0] evt_to_stat(input logic [N_EVT-1:0] e);
    return {e[N_EVT-1], 16'b0, e[N_EVT-2:0]};
  endfunction

  function automatic logic [TIM_W-1:0] tim_reset(input int idx);
    case (idx)
      0:       return 8'h19;
      1:       return 8'hFF;
      2:       return 8'h11;
      3:       return 8'h3A;
      default: return 8'h16;
    endcase
  endfunction

  function automatic logic [DW-1:0] tim_addr(input int idx);
    return 32'(A_TIM0) + 32'(4 * idx);
  endfunction

  function automatic logic pending(input logic [DW-1:0] st, input logic [DW-1:0] mk);
    return |(st & ~mk);
  endfunction
endpackage

// File: rtl/regbank_lock.sv
module regbank_lock
  import fuse_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_wr,
  input  logic [DW-1:0] wdata,
  output logic          locked
);
  logic key_match;
  assign key_match = (wdata == UNLOCK_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked <= 1'b1;
    else if (prot_wr) locked <= !key_match;
  end

  p_key_unlocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr |=> (locked == ($past(wdata) != UNLOCK_KEY)));

  p_hold_without_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_wr |=> $stable(locked));
endmodule

// File: rtl/regbank_irq.sv
module regbank_irq
  import fuse_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  input  logic [DW-1:0] unmask_vec,
  input  logic [DW-1:0] maskset_vec,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] mask_q,
  output logic          irq_o
);
  logic [DW-1:0] set_eff, clr_eff, unm_eff, mset_eff;
  assign set_eff  = set_vec     & STAT_LIVE;
  assign clr_eff  = clr_vec     & STAT_LIVE;
  assign unm_eff  = unmask_vec  & STAT_LIVE;
  assign mset_eff = maskset_vec & STAT_LIVE;

  // set is OR-ed after the clear so a coincident event survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_eff) | set_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= MASK_INIT;
    else        mask_q <= (mask_q & ~unm_eff) | mset_eff;
  end

  assign irq_o = pending(stat_q, mask_q);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(set_eff)) == $past(set_eff)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eff == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_unmask_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unm_eff != '0) |=> ((mask_q & $past(unm_eff)) == '0));

  p_maskset_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mset_eff != '0) |=> ((mask_q & $past(mset_eff)) == $past(mset_eff)));

  p_rsvd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~STAT_LIVE) == '0));
endmodule

// File: rtl/regbank_timing.sv
module regbank_timing
  import fuse_regbank_pkg::*;
#(
  parameter int N = N_TIM,
  parameter int W = TIM_W
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_hot,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_tim
    localparam logic [W-1:0] RST = W'(tim_reset(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q[g] <= RST;
      else if (wr_hot[g]) q[g] <= wdata;
    end

    p_only_own_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hot[g] |=> $stable(q[g]));
  end
endmodule

// File: rtl/fuse_irq_regbank.sv
module fuse_irq_regbank
  import fuse_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [15:0]   evt_i,
  output logic          irq_o
);
  logic                      locked;
  logic                      wr_ok;
  logic                      hit_prot, hit_stat, hit_mask, hit_unm, hit_mset;
  logic [N_TIM-1:0]          hit_tim;
  logic [DW-1:0]             stat_q, mask_q;
  logic [N_TIM-1:0][TIM_W-1:0] tim_q;

  assign hit_prot = (bus_addr_i == A_PROT);
  assign hit_stat = (bus_addr_i == A_STAT);
  assign hit_mask = (bus_addr_i == A_MASK);
  assign hit_unm  = (bus_addr_i == A_UNMASK);
  assign hit_mset = (bus_addr_i == A_MASKSET);

  for (genvar g = 0; g < N_TIM; g++) begin : g_dec
    assign hit_tim[g] = (32'(bus_addr_i) == tim_addr(g));
  end

  // passcode gate: only the protect register bypasses it
  assign wr_ok = bus_wr_i && !locked;

  regbank_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .prot_wr (bus_wr_i && hit_prot),
    .wdata   (bus_wdata_i),
    .locked  (locked)
  );

  regbank_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_vec     (evt_to_stat(evt_i)),
    .clr_vec     ((wr_ok && hit_stat) ? bus_wdata_i : '0),
    .unmask_vec  ((wr_ok && hit_unm)  ? bus_wdata_i : '0),
    .maskset_vec ((wr_ok && hit_mset) ? bus_wdata_i : '0),
    .stat_q      (stat_q),
    .mask_q      (mask_q),
    .irq_o       (irq_o)
  );

  regbank_timing #(.N(N_TIM), .W(TIM_W)) u_tim (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hot (wr_ok ? hit_tim : '0),
    .wdata  (bus_wdata_i[TIM_W-1:0]),
    .q      (tim_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (hit_prot) bus_rdata_o = {31'b0, locked};
    if (hit_stat) bus_rdata_o = stat_q;
    if (hit_mask) bus_rdata_o = mask_q;
    for (int i = 0; i < N_TIM; i++)
      if (hit_tim[i]) bus_rdata_o = 32'(tim_q[i]);
  end

  p_locked_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && locked && !hit_prot) |=> ($stable(mask_q) && $stable(tim_q)));

  p_mask_not_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && hit_mask) |=> $stable(mask_q));

  p_stat_only_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr_i && hit_stat) && evt_i == '0) |=> $stable(stat_q));
endmodule

// File: tb/fuse_irq_regbank_test.sv
module fuse_irq_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [7:0]  bus_addr_i = 8'h00;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [15:0] evt_i = '0;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic chk_req = 1'b0;
  logic done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          kind_q[$];

  fuse_irq_regbank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .evt_i(evt_i), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [15:0] ev);
    @(negedge clk);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d; evt_i = ev;
    @(negedge clk);
    bus_wr_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(input logic [15:0] ev);
    @(negedge clk);
    evt_i = ev;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr_i = a;
    exp_q.push_back(e); tag_q.push_back(tag); kind_q.push_back(1'b0);
    chk_req = 1'b1;
    @(negedge clk);
    chk_req = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    @(negedge clk);
    exp_q.push_back({31'b0, e}); tag_q.push_back(tag); kind_q.push_back(1'b1);
    chk_req = 1'b1;
    @(negedge clk);
    chk_req = 1'b0;
  endtask

  // monitor: samples 2 ns after the edge, away from both clock edges
  always begin
    @(posedge clk);
    #2;
    if (chk_req && exp_q.size() > 0) begin
      logic [31:0] e, act;
      string t;
      bit k;
      e = exp_q.pop_front(); t = tag_q.pop_front(); k = kind_q.pop_front();
      act = k ? {31'b0, irq_o} : bus_rdata_o;
      n_tests++;
      if (act !== e) begin
        n_fail++;
        $display("FAIL %s actual=0x%08h expected=0x%08h", t, act, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    expect_rd(8'h00, 32'h1,          "R1 protect reset");
    expect_rd(8'h08, 32'h8000_7FFF,  "R4 mask reset");
    expect_rd(8'h04, 32'h0,          "R3 status reset");
    expect_rd(8'h14, 32'h19,         "R8 timing0 reset");
    expect_rd(8'h18, 32'hFF,         "R8 timing1 reset");
    expect_rd(8'h1C, 32'h11,         "R8 timing2 reset");
    expect_rd(8'h20, 32'h3A,         "R8 timing3 reset");
    expect_rd(8'h24, 32'h16,         "R8 timing4 reset");
    expect_irq(1'b0,                 "R6 irq reset");

    // locked phase
    pulse(16'h0001);
    expect_rd(8'h04, 32'h1,          "R3 event sets bit0");
    expect_irq(1'b0,                 "R6 masked event no irq");
    wr(8'h0C, 32'hFFFF_FFFF, '0);
    expect_rd(8'h08, 32'h8000_7FFF,  "R2 locked unmask dropped");
    wr(8'h04, 32'h1, '0);
    expect_rd(8'h04, 32'h1,          "R2 locked w1c dropped");
    wr(8'h14, 32'hAA, '0);
    expect_rd(8'h14, 32'h19,         "R2 locked timing dropped");
    expect_irq(1'b0,                 "R2 locked irq unchanged");

    // protect key handling
    wr(8'h00, 32'h0000_DF0D, '0);
    expect_rd(8'h00, 32'h0,          "R1 key unlocks");
    wr(8'h00, 32'h0000_1234, '0);
    expect_rd(8'h00, 32'h1,          "R1 wrong value relocks");
    wr(8'h00, 32'h0001_DF0D, '0);
    expect_rd(8'h00, 32'h1,          "R1 near-key stays locked");
    wr(8'h00, 32'h0000_DF0D, '0);

    // unmask / mask-set
    wr(8'h0C, 32'h1, '0);
    expect_rd(8'h08, 32'h8000_7FFE,  "R5 unmask clears bit0");
    expect_irq(1'b1,                 "R6 unmasked pending raises irq");
    expect_rd(8'h0C, 32'h0,          "R5 unmask reads zero");
    expect_rd(8'h10, 32'h0,          "R5 mask-set reads zero");

    // w1c, bit 31, reserved bits
    wr(8'h04, 32'h1, '0);
    expect_rd(8'h04, 32'h0,          "R3 w1c clears bit0");
    expect_irq(1'b0,                 "R6 irq drops after clear");
    pulse(16'h8000);
    expect_rd(8'h04, 32'h8000_0000,  "R3 evt15 sets bit31");
    expect_irq(1'b0,                 "R6 bit31 masked");
    wr(8'h04, 32'h7FFF_8000, '0);
    expect_rd(8'h04, 32'h8000_0000,  "R3 reserved write no effect");
    wr(8'h0C, 32'h8000_0000, '0);
    expect_irq(1'b1,                 "R6 bit31 unmasked irq");
    wr(8'h10, 32'h8000_0000, '0);
    expect_rd(8'h08, 32'h8000_7FFE,  "R5 mask-set sets bit31");
    expect_irq(1'b0,                 "R6 remasked irq low");

    // sticky
    repeat (6) @(negedge clk);
    expect_rd(8'h04, 32'h8000_0000,  "R7 status sticky while idle");

    // coincident event and clear
    pulse(16'h0004);
    expect_rd(8'h04, 32'h8000_0004,  "R3 event sets bit2");
    wr(8'h04, 32'h0000_0004, 16'h0004);
    expect_rd(8'h04, 32'h8000_0004,  "R9 set wins over clear");
    wr(8'h04, 32'h8000_0000, 16'h0008);
    expect_rd(8'h04, 32'h0000_000C,  "R9 clear bit31 with event bit3");
    wr(8'h04, 32'h0000_000C, '0);
    expect_rd(8'h04, 32'h0,          "R3 clear after overlap");

    // direct mask write
    wr(8'h08, 32'h0, '0);
    expect_rd(8'h08, 32'h8000_7FFE,  "R4 direct mask write ignored");

    // timing write width
    wr(8'h18, 32'h1234_56C3, '0);
    expect_rd(8'h18, 32'hC3,         "R8 timing stores low byte");
    expect_rd(8'h1C, 32'h11,         "R8 neighbour unchanged");

    // unmapped
    wr(8'h40, 32'hFFFF_FFFF, '0);
    expect_rd(8'h40, 32'h0,          "R10 unmapped reads zero");
    expect_rd(8'h05, 32'h0,          "R10 misaligned reads zero");
    expect_rd(8'h08, 32'h8000_7FFE,  "R10 unmapped write left mask");
    expect_rd(8'h04, 32'h0,          "R10 unmapped write left status");

    // relock
    wr(8'h00, 32'h0, '0);
    expect_rd(8'h00, 32'h1,          "R1 zero relocks");
    wr(8'h18, 32'h55, '0);
    expect_rd(8'h18, 32'hC3,         "R2 relocked timing dropped");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule